// File: doc/BRIEF.md
# Bus Cycle Definition Generator

This block sits between a processor's access sources and its external bus. It accepts requests from three places: the instruction fetch unit, the load/store unit and a requester for special bus cycles. When no cycle is in progress it picks one request by fixed priority. For a fetch or operand access it checks the segment descriptor bits supplied with the request. A permitted access starts a bus cycle. The block pulses the address strobe and drives the three cycle-definition outputs (data/code, memory/IO, write/read) along with their shared output enable. A denied access starts no cycle and produces a one-cycle protection fault pulse instead.

The cycle stays outstanding until the ready input is seen. After that the definition outputs are released to the floated state. The block also captures a drive-strength selection from strap inputs while reset is held and keeps it once reset is released. That selection is reported per output group to the pad logic.

Top module: `bus_cycle_gen`

## Requirements
- R1: The outputs `dc`, `mio` and `wr` are registered and take their cycle values on the same clock edge that raises `def_oe` and pulses `ads`. They hold those values until `def_oe` falls, which happens on the edge where `rdy` is sampled high. While `def_oe` is low all three read 0.
- R2: A special-cycle request drives `{dc,mio,wr}` = 0,0,1 and is never denied.
- R3: A fetch cycle drives `dc`=0, `mio`=1 and `wr`=0. Fetches are always reads.
- R4: A load/store cycle drives `dc`=1, `mio` = inverse of `ls_io`, and `wr` = `ls_write`.
- R5: Requests are sampled only while idle. Priority is special first, then load/store, then fetch. One clock after sampling, exactly one of `ack_spec`, `ack_ls`, `ack_fetch` pulses for the winner, whether the winner was granted or denied. Losers get no acknowledge.
- R6: A fetch is permitted only when `fetch_exec` is 1 (code segment). With `fetch_exec` = 0 it is denied.
- R7: A load/store read is always permitted. A load/store write is denied when `ls_exec` = 1 (code segment) or when `ls_rw` = 0 (read-only data segment). It is permitted only when `ls_exec` = 0 and `ls_rw` = 1.
- R8: A denied access raises `fault` for exactly one clock, together with its acknowledge. No `ads` pulse occurs and `def_oe` stays low.
- R9: Only one cycle is outstanding. While `def_oe` is high, every request is ignored: no acknowledge, no `ads`, no `fault`. `ads` is high for exactly one clock per cycle. `rdy` has no effect while idle.
- R10: Strong drive is selected only when every strap input is 0 at the last clock edge sampled with `rst` high. Strap changes after reset is released have no effect.
- R11: `drv_strong` bit 0 (upper address group) is always 0. Bits 1 (lower address group), 2 (address strobe), 3 (hit-modified) and 4 (write/read) all equal the latched selection, where 1 means strong.
- R12: Out of reset, `ads`, `def_oe`, `dc`, `mio`, `wr`, `fault` and all acknowledges are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | Instruction fetch read request |
| fetch_exec | input | 1 | Execute bit of the code descriptor for the fetch |
| ls_req | input | 1 | Load/store operand request |
| ls_write | input | 1 | 1 = operand write, 0 = operand read |
| ls_io | input | 1 | 1 = I/O space, 0 = memory space |
| ls_exec | input | 1 | Execute bit of the operand segment descriptor |
| ls_rw | input | 1 | Read/write bit of the operand segment descriptor |
| spec_req | input | 1 | Special bus cycle request |
| rdy | input | 1 | Bus ready, ends the outstanding cycle |
| strap_in | input | STRAP_W | Drive-strength straps sampled during reset |
| ads | output | 1 | Address strobe, one clock per cycle |
| def_oe | output | 1 | Output enable of the three definition outputs |
| dc | output | 1 | Data/code definition |
| mio | output | 1 | Memory/IO definition |
| wr | output | 1 | Write/read definition |
| fault | output | 1 | Protection fault pulse |
| ack_fetch | output | 1 | Fetch request taken |
| ack_ls | output | 1 | Load/store request taken |
| ack_spec | output | 1 | Special request taken |
| drv_strong | output | 5 | Per-group drive strength, 1 = strong |

## Verification
The hardest situation to reach from the ports is a competing request that arrives while a cycle is still waiting for ready. Ignoring it must leave the held definition outputs untouched, and it must not be acknowledged later. To get there, random requests, including ones that would fault, are applied on every clock of a random wait window before `rdy` is raised. The second hard situation is the strap capture, because it depends on the last value sampled before reset falls. The bench repeats reset with each strap combination, switches the straps in the final reset clock, and toggles them after release.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_FETCH = 2'd1,
      SRC_LS    = 2'd2,
      SRC_SPEC  = 2'd3
   } src_e;

   typedef struct packed {
      logic dc;
      logic mio;
      logic wr;
   } cycdef_t;

   localparam int DRV_GROUPS   = 5;
   localparam int DRV_HI_ADDR  = 0;
   localparam int DRV_LO_ADDR  = 1;
   localparam int DRV_STROBE   = 2;
   localparam int DRV_HITMOD   = 3;
   localparam int DRV_WRRD     = 4;

   localparam cycdef_t DEF_IDLE    = '{dc: 1'b0, mio: 1'b0, wr: 1'b0};
   localparam cycdef_t DEF_SPECIAL = '{dc: 1'b0, mio: 1'b0, wr: 1'b1};
   localparam cycdef_t DEF_FETCH   = '{dc: 1'b0, mio: 1'b1, wr: 1'b0};

endpackage

// File: rtl/bcg_arbiter.sv
module bcg_arbiter
   import bcg_pkg::*;
(
   input  logic    fetch_req,
   input  logic    ls_req,
   input  logic    ls_write,
   input  logic    ls_io,
   input  logic    spec_req,
   output src_e    sel,
   output cycdef_t def_n
);

   always_comb begin
      sel   = SRC_NONE;
      def_n = DEF_IDLE;
      if (spec_req) begin
         sel   = SRC_SPEC;
         def_n = DEF_SPECIAL;
      end else if (ls_req) begin
         sel   = SRC_LS;
         def_n = '{dc: 1'b1, mio: ~ls_io, wr: ls_write};
      end else if (fetch_req) begin
         sel   = SRC_FETCH;
         def_n = DEF_FETCH;
      end
   end

endmodule

// File: rtl/bcg_perm_gate.sv
module bcg_perm_gate
   import bcg_pkg::*;
(
   input  src_e sel,
   input  logic fetch_exec,
   input  logic ls_write,
   input  logic ls_exec,
   input  logic ls_rw,
   output logic allow
);

   always_comb begin
      unique case (sel)
         SRC_FETCH: allow = fetch_exec;
         SRC_LS:    allow = ~ls_write | (~ls_exec & ls_rw);
         SRC_SPEC:  allow = 1'b1;
         default:   allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/bcg_drive_latch.sv
module bcg_drive_latch
   import bcg_pkg::*;
#(
   parameter int                    STRAP_W      = 2,
   parameter logic [DRV_GROUPS-1:0] LATCHED_MASK = 5'b11110
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic [STRAP_W-1:0]    strap_in,
   output logic [DRV_GROUPS-1:0] drv_strong
);

   logic strong_q;

   always_ff @(posedge clk) begin
      if (rst) strong_q <= ~|strap_in;
   end

   for (genvar g = 0; g < DRV_GROUPS; g++) begin : g_grp
      if (LATCHED_MASK[g]) begin : g_follow
         assign drv_strong[g] = strong_q;
      end else begin : g_weak
         assign drv_strong[g] = 1'b0;
      end
   end

   p_drive_hold_r10: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> $stable(strong_q));

endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
   import bcg_pkg::*;
#(
   parameter int                    STRAP_W      = 2,
   parameter logic [DRV_GROUPS-1:0] LATCHED_MASK = 5'b11110
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  fetch_req,
   input  logic                  fetch_exec,
   input  logic                  ls_req,
   input  logic                  ls_write,
   input  logic                  ls_io,
   input  logic                  ls_exec,
   input  logic                  ls_rw,
   input  logic                  spec_req,
   input  logic                  rdy,
   input  logic [STRAP_W-1:0]    strap_in,
   output logic                  ads,
   output logic                  def_oe,
   output logic                  dc,
   output logic                  mio,
   output logic                  wr,
   output logic                  fault,
   output logic                  ack_fetch,
   output logic                  ack_ls,
   output logic                  ack_spec,
   output logic [DRV_GROUPS-1:0] drv_strong
);

   if (STRAP_W < 1) begin : g_bad_strap
      $error("STRAP_W must be at least 1");
   end
   if (LATCHED_MASK[DRV_HI_ADDR]) begin : g_bad_mask
      $error("upper address group must stay weak");
   end

   typedef enum logic {ST_IDLE, ST_BUSY} state_e;

   state_e  state_q;
   cycdef_t def_q;
   cycdef_t def_n;
   src_e    sel;
   logic    allow;

   bcg_arbiter u_arb (
      .fetch_req (fetch_req),
      .ls_req    (ls_req),
      .ls_write  (ls_write),
      .ls_io     (ls_io),
      .spec_req  (spec_req),
      .sel       (sel),
      .def_n     (def_n)
   );

   bcg_perm_gate u_gate (
      .sel        (sel),
      .fetch_exec (fetch_exec),
      .ls_write   (ls_write),
      .ls_exec    (ls_exec),
      .ls_rw      (ls_rw),
      .allow      (allow)
   );

   bcg_drive_latch #(
      .STRAP_W      (STRAP_W),
      .LATCHED_MASK (LATCHED_MASK)
   ) u_drv (
      .clk        (clk),
      .rst        (rst),
      .strap_in   (strap_in),
      .drv_strong (drv_strong)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         def_q     <= DEF_IDLE;
         def_oe    <= 1'b0;
         ads       <= 1'b0;
         fault     <= 1'b0;
         ack_fetch <= 1'b0;
         ack_ls    <= 1'b0;
         ack_spec  <= 1'b0;
      end else begin
         ads       <= 1'b0;
         fault     <= 1'b0;
         ack_fetch <= 1'b0;
         ack_ls    <= 1'b0;
         ack_spec  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (sel != SRC_NONE) begin
                  ack_fetch <= (sel == SRC_FETCH);
                  ack_ls    <= (sel == SRC_LS);
                  ack_spec  <= (sel == SRC_SPEC);
                  if (allow) begin
                     ads     <= 1'b1;
                     def_oe  <= 1'b1;
                     def_q   <= def_n;
                     state_q <= ST_BUSY;
                  end else begin
                     fault   <= 1'b1;
                  end
               end
            end
            ST_BUSY: begin
               if (rdy) begin
                  def_oe  <= 1'b0;
                  def_q   <= DEF_IDLE;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dc  = def_q.dc;
   assign mio = def_q.mio;
   assign wr  = def_q.wr;

   p_oe_with_strobe_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(def_oe) |-> ads);
   p_float_low_r1: assert property (@(posedge clk) disable iff (rst)
      !def_oe |-> ({dc, mio, wr} == 3'b000));
   p_def_hold_r1: assert property (@(posedge clk) disable iff (rst)
      (def_oe && $past(def_oe)) |-> $stable({dc, mio, wr}));
   p_special_enc_r2: assert property (@(posedge clk) disable iff (rst)
      (ads && ack_spec) |-> ({dc, mio, wr} == 3'b001));
   p_fetch_read_r3: assert property (@(posedge clk) disable iff (rst)
      (ads && ack_fetch) |-> ({dc, mio, wr} == 3'b010));
   p_ack_single_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ack_fetch, ack_ls, ack_spec}));
   p_fault_no_cycle_r8: assert property (@(posedge clk) disable iff (rst)
      fault |-> (!ads && !def_oe));
   p_strobe_once_r9: assert property (@(posedge clk) disable iff (rst)
      ads |=> !ads);
   p_hi_weak_r11: assert property (@(posedge clk) disable iff (rst)
      !drv_strong[DRV_HI_ADDR]);

endmodule

// File: tb/tb_bus_cycle_gen.sv
module tb_bus_cycle_gen;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic fetch_req = 0, fetch_exec = 0, ls_req = 0, ls_write = 0, ls_io = 0;
   logic ls_exec = 0, ls_rw = 0, spec_req = 0, rdy = 0;
   logic [1:0] strap_in = 2'b00;
   logic ads, def_oe, dc, mio, wr, fault, ack_fetch, ack_ls, ack_spec;
   logic [4:0] drv_strong;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bus_cycle_gen dut (
      .clk(clk), .rst(rst),
      .fetch_req(fetch_req), .fetch_exec(fetch_exec),
      .ls_req(ls_req), .ls_write(ls_write), .ls_io(ls_io),
      .ls_exec(ls_exec), .ls_rw(ls_rw), .spec_req(spec_req),
      .rdy(rdy), .strap_in(strap_in),
      .ads(ads), .def_oe(def_oe), .dc(dc), .mio(mio), .wr(wr),
      .fault(fault), .ack_fetch(ack_fetch), .ack_ls(ack_ls),
      .ack_spec(ack_spec), .drv_strong(drv_strong)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_reqs();
      fetch_req = 0; fetch_exec = 0; ls_req = 0; ls_write = 0; ls_io = 0;
      ls_exec = 0; ls_rw = 0; spec_req = 0;
   endtask

   task automatic rand_reqs();
      fetch_req = 1'($urandom); fetch_exec = 1'($urandom);
      ls_req = 1'($urandom); ls_write = 1'($urandom); ls_io = 1'($urandom);
      ls_exec = 1'($urandom); ls_rw = 1'($urandom);
      spec_req = (($urandom % 4) == 0);
   endtask

   // Expected outcome from the requirements. ack bits: [2] spec, [1] ls, [0] fetch
   task automatic model(output logic [2:0] ack, output logic st,
                        output logic flt, output logic [2:0] d, output string tag);
      logic ok;
      ack = 3'b000; st = 0; flt = 0; d = 3'b000; ok = 0; tag = "R5 idle";
      if (spec_req) begin
         ack = 3'b100; ok = 1; d = 3'b001; tag = "R2";
      end else if (ls_req) begin
         ack = 3'b010; d = {1'b1, ~ls_io, ls_write};
         ok = !ls_write || (!ls_exec && ls_rw); tag = ok ? "R4" : "R7";
      end else if (fetch_req) begin
         ack = 3'b001; d = 3'b010; ok = fetch_exec; tag = ok ? "R3" : "R6";
      end
      if (ack != 0) begin
         st = ok; flt = !ok;
         if (!ok) d = 3'b000;
      end
   endtask

   task automatic run_cycle(input int wait_cycles);
      logic [2:0] eack, ed;
      logic est, eflt;
      string tag;
      rdy = 0;
      model(eack, est, eflt, ed, tag);
      @(posedge clk); #1;
      chk({ack_spec, ack_ls, ack_fetch} == eack, {"R5 ack ", tag},
          {ack_spec, ack_ls, ack_fetch}, eack);
      chk(ads == est, {"R1 ads ", tag}, ads, est);
      chk(def_oe == est, {"R1 oe ", tag}, def_oe, est);
      chk({dc, mio, wr} == ed, {"R1 def ", tag}, {dc, mio, wr}, ed);
      chk(fault == eflt, {"R8 fault ", tag}, fault, eflt);
      @(negedge clk); clear_reqs();
      @(posedge clk); #1;
      chk(fault == 0 && ads == 0, "R8 pulse", {fault, ads}, 0);
      chk(def_oe == est, "R1 oe hold", def_oe, est);
      if (est) begin
         for (int k = 0; k < wait_cycles; k++) begin
            @(negedge clk); rand_reqs(); rdy = 0;
            @(posedge clk); #1;
            chk({ack_spec, ack_ls, ack_fetch, ads, fault} == 0, "R9 ignored",
                {ack_spec, ack_ls, ack_fetch, ads, fault}, 0);
            chk(def_oe == 1 && {dc, mio, wr} == ed, "R1 held",
                {def_oe, dc, mio, wr}, {1'b1, ed});
         end
         @(negedge clk); rand_reqs(); rdy = 1;
         @(posedge clk); #1;
         chk(def_oe == 0 && {dc, mio, wr} == 0, "R1 release",
             {def_oe, dc, mio, wr}, 0);
         chk({ack_spec, ack_ls, ack_fetch, ads} == 0, "R9 ready edge",
             {ack_spec, ack_ls, ack_fetch, ads}, 0);
         @(negedge clk); rdy = 0; clear_reqs();
      end
   endtask

   task automatic set_req(input logic f, fx, l, lw, lio, lx, lrw, s);
      @(negedge clk);
      fetch_req = f; fetch_exec = fx; ls_req = l; ls_write = lw; ls_io = lio;
      ls_exec = lx; ls_rw = lrw; spec_req = s;
   endtask

   task automatic strap_test(input logic [1:0] s_early, input logic [1:0] s_last);
      logic [4:0] e;
      @(negedge clk); rst = 1; strap_in = s_early;
      @(posedge clk); @(negedge clk); strap_in = s_last;
      @(posedge clk); @(negedge clk); rst = 0; strap_in = ~s_last;
      e = (s_last == 2'b00) ? 5'b11110 : 5'b00000;
      @(posedge clk); #1;
      chk(drv_strong == e, "R10 R11 latch", drv_strong, e);
      @(negedge clk); strap_in = 2'($urandom);
      repeat (3) @(posedge clk); #1;
      chk(drv_strong == e, "R10 strap ignored", drv_strong, e);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1c0de));
      strap_in = 2'b00;
      repeat (3) @(posedge clk);
      #1;
      chk({ads, def_oe, dc, mio, wr, fault, ack_fetch, ack_ls, ack_spec} == 0,
          "R12 reset", {ads, def_oe, dc, mio, wr, fault, ack_fetch, ack_ls, ack_spec}, 0);
      @(negedge clk); rst = 0;
      @(posedge clk); #1;
      chk({ads, def_oe, fault} == 0, "R12 after release", {ads, def_oe, fault}, 0);
      chk(drv_strong == 5'b11110, "R11 strong groups", drv_strong, 5'b11110);

      // rdy while idle has no effect (R9)
      @(negedge clk); rdy = 1;
      @(posedge clk); #1;
      chk({ads, def_oe, fault} == 0, "R9 idle ready", {ads, def_oe, fault}, 0);
      @(negedge clk); rdy = 0;

      // directed corners
      set_req(1, 1, 0, 0, 0, 0, 0, 0); run_cycle(1);  // R3 fetch ok
      set_req(1, 0, 0, 0, 0, 0, 0, 0); run_cycle(0);  // R6 fetch from data seg
      set_req(0, 0, 1, 1, 0, 1, 1, 0); run_cycle(0);  // R7 write to code seg
      set_req(0, 0, 1, 1, 0, 0, 0, 0); run_cycle(0);  // R7 write read-only
      set_req(0, 0, 1, 1, 1, 0, 1, 0); run_cycle(2);  // R4 io write ok
      set_req(0, 0, 1, 0, 0, 1, 0, 0); run_cycle(0);  // R7 read of code seg
      set_req(1, 1, 1, 1, 0, 1, 0, 1); run_cycle(3);  // R2 special wins
      set_req(1, 1, 1, 1, 0, 0, 0, 0); run_cycle(0);  // R5 ls wins, faults
      set_req(0, 0, 0, 0, 0, 0, 0, 1); run_cycle(0);  // R2 immediate ready

      for (int i = 0; i < 400; i++) begin
         @(negedge clk); rand_reqs();
         run_cycle(int'($urandom % 4));
      end

      strap_test(2'b11, 2'b00);
      strap_test(2'b00, 2'b01);
      strap_test(2'b00, 2'b10);
      strap_test(2'b01, 2'b11);
      strap_test(2'b10, 2'b00);

      // function after re-reset with weak straps
      @(negedge clk); rst = 1; strap_in = 2'b11;
      @(posedge clk); @(negedge clk); rst = 0;
      set_req(0, 0, 1, 0, 1, 0, 0, 0); run_cycle(1);  // R4 io read
      @(posedge clk); #1;
      chk(drv_strong == 5'b00000, "R11 weak groups", drv_strong, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule